// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash model. It watches host write cycles (address, data and an active-low write strobe) on a synchronous clock and recognises multi-cycle unlock sequences. Four commands are decoded: entry into a secondary one-time-programmable area, a program of one location in that area, exit from that area, and a single-cycle reset to read mode. The block does not contain the memory array. A program command produces a one-cycle strobe that carries the captured area address and data, and a downstream storage model consumes it.

A mode input selects word or byte addressing. In byte mode the address bus is one bit wider, and the extra bit sits in the least-significant position below the word address bits. In word mode the top address input bit is ignored. Only the low eleven word-address bits, plus the extra bit in byte mode, take part in the unlock comparisons. The upper bits are ignored except where the bank field or the program address is checked. Commands are carried in the low data byte.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, sec_mode_o is 0 and prog_valid_o is 0.
- R2: A write cycle is taken only in the clock cycle in which we_ni is first seen low after being high. Holding we_ni low for further cycles adds no cycles. Outputs change on the clock edge that samples that cycle.
- R3: The first unlock cycle is data AAh at word address bits [10:0] = 555h, and in byte mode the extra bit must also be 0 (byte address AAAh). The second unlock cycle is data 55h at [10:0] = 2AAh, and in byte mode the extra bit must also be 1 (byte address 555h). The upper address bits and the upper data byte are ignored.
- R4: Two unlock cycles followed by data 88h at the first unlock address set sec_mode_o to 1.
- R5: In area mode, two unlock cycles, then A0h at the first unlock address, then any fourth cycle with an in-range address produce prog_valid_o high for exactly one cycle. A fourth-cycle data byte of F0h is taken as program data and not as a reset.
- R6: The program is rejected, with no strobe, when the word address is at or above 80h (byte address at or above 100h), or when A0h arrives while sec_mode_o is 0. A rejected sequence returns to the idle step.
- R7: In area mode, two unlock cycles, then 90h at the first unlock address with bank bits A21..A19 all 0, then a write of 00h clear sec_mode_o. A third cycle with any bank bit set aborts, and sec_mode_o stays 1.
- R8: A data byte of F0h in any step except the program-data step returns to the idle step and clears sec_mode_o.
- R9: Any write that does not match the expected address and data of the current step returns to the idle step, so a full sequence is needed again.
- R10: prog_addr_o is 8 bits. In word mode it is {0, A6..A0}. In byte mode it is {A6..A0, extra bit}. prog_data_o is the full 16-bit data in word mode and {00h, low byte} in byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_mode_i | input | 1 | 1 = byte addressing, 0 = word addressing |
| we_ni | input | 1 | Active-low write strobe |
| addr_i | input | 23 | Host address. Bit 0 is the extra low bit in byte mode. Bit 22 is ignored in word mode |
| data_i | input | 16 | Host write data. Commands use bits [7:0] |
| sec_mode_o | output | 1 | 1 while the secondary area is selected |
| prog_valid_o | output | 1 | One-cycle program strobe |
| prog_addr_o | output | 8 | Area address of the program |
| prog_data_o | output | 16 | Program data |

## Verification
The reset value F0h and the program data can fall in the same cycle. When a program sequence ends with a fourth write whose data byte is F0h, that write is both a reset code and program data. The bench provokes this with directed writes in both addressing modes. Random programs with F0h data also occur. The expected result is a strobe that carries F0h with sec_mode_o still 1, and this is judged against the bench reference model at the clock edge after the write. The same model shows that an F0h in the exit step clears the mode, so the priority between the two meanings depends only on the step.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_EXIT
  } seq_step_e;

  localparam int unsigned UNLOCK_W = 11;
  localparam logic [UNLOCK_W-1:0] UNLOCK_ADDR_A = 11'h555;
  localparam logic [UNLOCK_W-1:0] UNLOCK_ADDR_B = 11'h2AA;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_ENTER = 8'h88;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_LEAVE = 8'h90;
  localparam logic [7:0] CMD_DONE  = 8'h00;
  localparam logic [7:0] CMD_RESET = 8'hF0;
endpackage

// File: rtl/flash_we_edge.sv
module flash_we_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_ni,
  output logic wr_o
);
  logic we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;
  end

  assign wr_o = we_q & ~we_ni;

  // a held strobe yields one write only
  p_single_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
endmodule

// File: rtl/flash_addr_match.sv
module flash_addr_match #(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned SEC_WORDS = 128,
  localparam int unsigned AI_W     = ADDR_W + 1,
  localparam int unsigned SEC_AW   = $clog2(SEC_WORDS),
  localparam int unsigned PA_W     = SEC_AW + 1
) (
  input  logic            byte_mode_i,
  input  logic [AI_W-1:0] addr_i,
  output logic            hit_a_o,
  output logic            hit_b_o,
  output logic            bank_zero_o,
  output logic            in_area_o,
  output logic [PA_W-1:0] area_addr_o
);
  import flash_cmd_pkg::*;

  logic [ADDR_W-1:0] waddr;
  logic              lsb;

  // word view of the bus; byte mode shifts out the extra low bit
  assign waddr = byte_mode_i ? addr_i[AI_W-1:1] : addr_i[ADDR_W-1:0];
  assign lsb   = addr_i[0];

  // byte AAAh = word 555h with lsb 0, byte 555h = word 2AAh with lsb 1
  assign hit_a_o = (waddr[UNLOCK_W-1:0] == UNLOCK_ADDR_A) && (!byte_mode_i || !lsb);
  assign hit_b_o = (waddr[UNLOCK_W-1:0] == UNLOCK_ADDR_B) && (!byte_mode_i || lsb);

  assign bank_zero_o = (waddr[ADDR_W-1 -: BANK_W] == '0);
  assign in_area_o   = (waddr[ADDR_W-1:SEC_AW] == '0);

  always_comb begin
    if (byte_mode_i) area_addr_o = {waddr[SEC_AW-1:0], lsb};
    else             area_addr_o = {1'b0, waddr[SEC_AW-1:0]};
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SEC_WORDS = 128,
  localparam int unsigned SEC_AW   = $clog2(SEC_WORDS),
  localparam int unsigned PA_W     = SEC_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              byte_mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hit_a_i,
  input  logic              hit_b_i,
  input  logic              bank_zero_i,
  input  logic              in_area_i,
  input  logic [PA_W-1:0]   area_addr_i,
  output logic              sec_mode_o,
  output logic              prog_valid_o,
  output logic [PA_W-1:0]   prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o
);
  import flash_cmd_pkg::*;

  seq_step_e   step_q, step_d;
  logic        sec_d;
  logic        pv_d;
  logic [7:0]  cmd;
  logic        is_reset;
  logic [DATA_W-1:0] pdata;

  assign cmd      = data_i[7:0];
  assign is_reset = (cmd == CMD_RESET);
  assign pdata    = byte_mode_i ? {{(DATA_W-8){1'b0}}, data_i[7:0]} : data_i;

  always_comb begin
    step_d = step_q;
    sec_d  = sec_mode_o;
    pv_d   = 1'b0;
    if (wr_i) begin
      step_d = ST_IDLE;
      unique case (step_q)
        ST_IDLE: begin
          if (is_reset) sec_d = 1'b0;
          else if (hit_a_i && cmd == CMD_KEY1) step_d = ST_UNL1;
        end
        ST_UNL1: begin
          if (is_reset) sec_d = 1'b0;
          else if (hit_b_i && cmd == CMD_KEY2) step_d = ST_UNL2;
        end
        ST_UNL2: begin
          if (is_reset) sec_d = 1'b0;
          else if (hit_a_i) begin
            if (cmd == CMD_ENTER) sec_d = 1'b1;
            else if (cmd == CMD_PROG && sec_mode_o) step_d = ST_PROG;
            else if (cmd == CMD_LEAVE && sec_mode_o && bank_zero_i) step_d = ST_EXIT;
          end
        end
        // data here is payload, so F0h is not a reset
        ST_PROG: pv_d = in_area_i;
        ST_EXIT: begin
          if (cmd == CMD_DONE || is_reset) sec_d = 1'b0;
        end
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q       <= ST_IDLE;
      sec_mode_o   <= 1'b0;
      prog_valid_o <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
    end else begin
      step_q       <= step_d;
      sec_mode_o   <= sec_d;
      prog_valid_o <= pv_d;
      if (pv_d) begin
        prog_addr_o <= area_addr_i;
        prog_data_o <= pdata;
      end
    end
  end

  p_strobe_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |=> !prog_valid_o);

  p_strobe_in_area_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |-> sec_mode_o);

  p_enter_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_mode_o) |-> $past(wr_i));

  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(sec_mode_o));

  p_word_addr_top_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !byte_mode_i && step_q == ST_PROG) |=> !prog_valid_o || !prog_addr_o[PA_W-1]);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned SEC_WORDS = 128,
  localparam int unsigned AI_W     = ADDR_W + 1,
  localparam int unsigned PA_W     = $clog2(SEC_WORDS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_mode_i,
  input  logic              we_ni,
  input  logic [AI_W-1:0]   addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sec_mode_o,
  output logic              prog_valid_o,
  output logic [PA_W-1:0]   prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o
);
  logic            wr;
  logic            hit_a, hit_b, bank_zero, in_area;
  logic [PA_W-1:0] area_addr;

  flash_we_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_ni  (we_ni),
    .wr_o   (wr)
  );

  flash_addr_match #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .SEC_WORDS (SEC_WORDS)
  ) u_match (
    .byte_mode_i (byte_mode_i),
    .addr_i      (addr_i),
    .hit_a_o     (hit_a),
    .hit_b_o     (hit_b),
    .bank_zero_o (bank_zero),
    .in_area_o   (in_area),
    .area_addr_o (area_addr)
  );

  flash_seq_fsm #(
    .DATA_W    (DATA_W),
    .SEC_WORDS (SEC_WORDS)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr),
    .byte_mode_i  (byte_mode_i),
    .data_i       (data_i),
    .hit_a_i      (hit_a),
    .hit_b_i      (hit_b),
    .bank_zero_i  (bank_zero),
    .in_area_i    (in_area),
    .area_addr_i  (area_addr),
    .sec_mode_o   (sec_mode_o),
    .prog_valid_o (prog_valid_o),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o)
  );
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b0;
  logic        we_n = 1'b1;
  logic [22:0] addr = '0;
  logic [15:0] data = '0;
  logic        sec_mode, prog_valid;
  logic [7:0]  prog_addr;
  logic [15:0] prog_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // reference state
  int          m_step = 0;
  logic        m_sec = 0;
  logic        e_pv;
  logic [7:0]  e_pa;
  logic [15:0] e_pd;

  always #2.5 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .byte_mode_i  (byte_mode),
    .we_ni        (we_n),
    .addr_i       (addr),
    .data_i       (data),
    .sec_mode_o   (sec_mode),
    .prog_valid_o (prog_valid),
    .prog_addr_o  (prog_addr),
    .prog_data_o  (prog_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [22:0] mk(logic bm, logic [21:0] w, logic lsb);
    return bm ? {w, lsb} : {lsb, w};
  endfunction

  // reference model built from the requirements
  task automatic ref_apply(logic [22:0] a, logic [15:0] d, logic bm);
    logic [21:0] w;
    logic la, lb;
    logic [7:0] c;
    w  = bm ? a[22:1] : a[21:0];
    la = (w[10:0] == 11'h555) && (!bm || !a[0]);
    lb = (w[10:0] == 11'h2AA) && (!bm || a[0]);
    c  = d[7:0];
    e_pv = 1'b0;
    case (m_step)
      0: begin
        if (c == 8'hF0) m_sec = 0;
        else if (la && c == 8'hAA) m_step = 1;
      end
      1: begin
        m_step = 0;
        if (c == 8'hF0) m_sec = 0;
        else if (lb && c == 8'h55) m_step = 2;
      end
      2: begin
        m_step = 0;
        if (c == 8'hF0) m_sec = 0;
        else if (la && c == 8'h88) m_sec = 1;
        else if (la && c == 8'hA0 && m_sec) m_step = 3;
        else if (la && c == 8'h90 && m_sec && w[21:19] == 3'b000) m_step = 4;
      end
      3: begin
        m_step = 0;
        if (w[21:7] == '0) begin
          e_pv = 1'b1;
          e_pa = bm ? {w[6:0], a[0]} : {1'b0, w[6:0]};
          e_pd = bm ? {8'h00, d[7:0]} : d;
        end
      end
      default: begin
        m_step = 0;
        if (c == 8'h00 || c == 8'hF0) m_sec = 0;
      end
    endcase
  endtask

  task automatic wr(logic [22:0] a, logic [15:0] d, logic bm, string req, int hold = 1);
    @(negedge clk);
    addr = a; data = d; byte_mode = bm; we_n = 1'b0;
    ref_apply(a, d, bm);
    repeat (hold) @(negedge clk);
    we_n = 1'b1;
    chk(req, sec_mode, m_sec);
    chk(req, prog_valid, (hold == 1) ? e_pv : 1'b0);
    if (e_pv && hold == 1) begin
      chk(req, prog_addr, e_pa);
      chk(req, prog_data, e_pd);
    end
    @(negedge clk);
    chk(req, prog_valid, 1'b0);
  endtask

  function automatic logic [10:0] rhi();
    return 11'($urandom);
  endfunction

  task automatic key(logic bm, string req, int hold = 1);
    wr(mk(bm, {rhi(), 11'h555}, bm ? 1'b0 : 1'($urandom)), 16'($urandom) & 16'hFF00 | 16'h00AA, bm, req, hold);
    wr(mk(bm, {rhi(), 11'h2AA}, bm ? 1'b1 : 1'($urandom)), 16'h0055, bm, req, hold);
  endtask

  task automatic third(logic bm, logic [7:0] c, logic [2:0] bank, string req);
    wr(mk(bm, {bank, 8'($urandom), 11'h555}, bm ? 1'b0 : 1'($urandom)), {8'($urandom), c}, bm, req);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", sec_mode, 0);
    chk("R1", prog_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", sec_mode, 0);

    // R3/R4 word entry with junk upper bits
    key(0, "R3");
    third(0, 8'h88, 3'b101, "R4");
    // R5/R10 word program
    key(0, "R5");
    third(0, 8'hA0, 3'b000, "R5");
    wr(mk(0, 22'h000005, 1'b1), 16'hBEEF, 0, "R10");
    // program data F0h collides with reset code
    key(0, "R5");
    third(0, 8'hA0, 3'b000, "R5");
    wr(mk(0, 22'h00007F, 1'b0), 16'h12F0, 0, "R5");
    chk("R8", sec_mode, 1);
    // R6 out of range
    key(0, "R6");
    third(0, 8'hA0, 3'b000, "R6");
    wr(mk(0, 22'h000080, 1'b0), 16'h1111, 0, "R6");
    // R7 exit with bank bit set aborts
    key(0, "R7");
    third(0, 8'h90, 3'b001, "R7");
    wr(mk(0, 22'h000000, 1'b0), 16'h0000, 0, "R7");
    chk("R7", sec_mode, 1);
    // R7 proper exit
    key(0, "R7");
    third(0, 8'h90, 3'b000, "R7");
    wr(mk(0, 22'h000000, 1'b0), 16'h0000, 0, "R7");
    chk("R7", sec_mode, 0);
    // R6 program in normal mode
    key(0, "R6");
    third(0, 8'hA0, 3'b000, "R6");
    wr(mk(0, 22'h000003, 1'b0), 16'h2222, 0, "R6");
    // R2 held strobe counts once
    key(1, "R2", 3);
    third(1, 8'h88, 3'b000, "R2");
    chk("R2", sec_mode, 1);
    // R10 byte program at top, then out of range
    key(1, "R10");
    third(1, 8'hA0, 3'b000, "R10");
    wr(mk(1, 22'h00007F, 1'b1), 16'h12AB, 1, "R10");
    key(1, "R6");
    third(1, 8'hA0, 3'b000, "R6");
    wr(mk(1, 22'h000080, 1'b0), 16'h0033, 1, "R6");
    // byte program with F0h data
    key(1, "R5");
    third(1, 8'hA0, 3'b000, "R5");
    wr(mk(1, 22'h000010, 1'b1), 16'h00F0, 1, "R5");
    // R8 reset in third step
    key(1, "R8");
    wr(mk(1, 22'h000555, 1'b0), 16'h00F0, 1, "R8");
    chk("R8", sec_mode, 0);
    // R9 mismatch in second step
    wr(mk(0, 22'h000555, 1'b0), 16'h00AA, 0, "R9");
    wr(mk(0, 22'h000555, 1'b0), 16'h0055, 0, "R9");
    wr(mk(0, 22'h000555, 1'b0), 16'h0088, 0, "R9");
    chk("R9", sec_mode, 0);
    // R3 byte unlock with wrong low bit
    wr(mk(1, 22'h000555, 1'b1), 16'h00AA, 1, "R3");
    wr(mk(1, 22'h0002AA, 1'b1), 16'h0055, 1, "R3");
    third(1, 8'h88, 3'b000, "R3");
    chk("R3", sec_mode, 0);

    for (int i = 0; i < 300; i++) begin
      logic bm;
      int op;
      bm = 1'($urandom);
      op = int'($urandom % 6);
      case (op)
        0: begin key(bm, "R4"); third(bm, 8'h88, 3'($urandom), "R4"); end
        1: begin
          key(bm, "R5");
          third(bm, 8'hA0, 3'($urandom), "R5");
          wr(mk(bm, ($urandom % 4 != 0) ? 22'($urandom % 128) : 22'($urandom), 1'($urandom)),
             16'($urandom), bm, "R6");
        end
        2: begin
          key(bm, "R7");
          third(bm, 8'h90, ($urandom % 4 != 0) ? 3'b000 : 3'($urandom), "R7");
          wr(mk(bm, 22'($urandom), 1'($urandom)), ($urandom % 4 != 0) ? 16'h0000 : 16'($urandom), bm, "R7");
        end
        3: wr(23'($urandom), 16'($urandom), bm, "R9");
        4: wr(23'($urandom), 16'h00F0, bm, "R8");
        default: begin
          wr(mk(bm, {rhi(), 11'h555}, 1'b0), 16'h00AA, bm, "R9");
          wr(23'($urandom), 16'($urandom), bm, "R9");
        end
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule